// File: doc/BRIEF.md
# Pulsed-Strobe Order Detector

This block is a synchronous finite-state machine that watches four single-cycle strobe lines and raises one level output once the strobes have arrived in a fixed order. Numbering the lines 1 to 4, the order is line 2, then line 4, then line 3, then line 1. Upstream logic produces each strobe as a pulse one clock wide, synchronous to the block clock. The detector samples the strobes on every rising edge. A cycle in which no strobe is active leaves the machine where it is, so idle gaps of any length may separate the steps.

The machine has five states, and each is visible on a debug port. They are IDLE (code 0, nothing matched), FIRST (code 1, line 2 seen), SECOND (code 2, lines 2 and 4 seen), THIRD (code 3, lines 2, 4 and 3 seen) and MATCH (code 4, full order seen). The transitions are named as follows:
- *advance*: the expected strobe moves the machine one step forward.
- *complete*: the line 1 strobe in THIRD moves the machine to MATCH.
- *repeat-drop*: a strobe on the same line as the previous strobe sends the machine to IDLE.
- *restart*: an out-of-order line 2 strobe sends the machine to FIRST.
- *mismatch-drop*: any other out-of-order strobe sends the machine to IDLE.
- *collision-drop*: two or more strobes in the same cycle send the machine to IDLE and clear the record of the previous strobe.
- *hold*: a cycle with no strobe keeps the state.

The match output comes from a register and depends only on the state. It stays high until the next strobe or a reset.

Top module: `seq_pulse_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes IDLE (0), `match_o` becomes 0 and the record of the previous strobe is cleared. Reset is synchronous and active high.
- R2: Single strobes on `strobe_i` bit 1, then bit 3, then bit 2, then bit 0 (lines 2, 4, 3, 1), with none repeating the previous line, take the state to MATCH (4). `match_o` is 1 after the rising edge that samples the bit 0 strobe.
- R3: The *advance* transitions are IDLE to FIRST (1) on bit 1, FIRST to SECOND (2) on bit 3, and SECOND to THIRD (3) on bit 2. `match_o` stays 0 in these states.
- R4: A single strobe on the same line as the previous accepted strobe sends the state to IDLE, whatever the state. This holds for line 2 as well, and idle cycles between the two strobes do not matter.
- R5: A single strobe that is neither expected, nor a repeat, nor on bit 1 sends the state to IDLE. In MATCH, every such strobe counts as unexpected.
- R6: A single strobe on bit 1 that is not expected and not a repeat sends the state to FIRST. This includes a bit 1 strobe in MATCH.
- R7: A cycle with `strobe_i` equal to 0 leaves both the state and `match_o` unchanged.
- R8: A cycle with more than one bit of `strobe_i` set sends the state to IDLE and drives `match_o` to 0. It also clears the record of the previous strobe, so the next single strobe is never treated as a repeat.
- R9: `match_o` is 1 exactly when the state is MATCH. It stays 1 through idle cycles until the next strobe or a reset.
- R10: `state_o` shows the current state with the codes IDLE=0, FIRST=1, SECOND=2, THIRD=3, MATCH=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | NUM_LINES (4) | Single-cycle strobes; bit k is line k+1 |
| match_o | output | 1 | Registered level output, high in MATCH |
| state_o | output | 3 | Current state code for debug |

## Verification
The bench targets four corner cases:
- **Repeat on line 2.** The line 2 strobe is both the start symbol and a possible repeat. A design that lets the restart rule win would go to FIRST, where it should fall to IDLE.
- **Strobe after MATCH.** A design that forgot which line completed the match, or that held MATCH on a strobe, would show a wrong state or keep `match_o` high.
- **Collision cycle.** Several strobes in one cycle must clear the repeat record. A design that kept the record would drop a following strobe on that same line to IDLE, where it should be accepted.
- **Idle gaps.** These show whether the state drifts or the repeat record is lost between strobes.

Every ordered four-strobe word over the four lines is swept with varying gaps. A long pseudo-random run, mixing collisions and idle cycles, is then compared step by step with a progress counter kept in the bench.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    // Machine states; the codes are visible on the debug port.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FIRST  = 3'd1,
        ST_SECOND = 3'd2,
        ST_THIRD  = 3'd3,
        ST_MATCH  = 3'd4
    } seq_state_e;

    localparam int STATE_W = 3;

    // Summary of one cycle of strobes.
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MULTI  = 2'd2
    } strobe_cls_e;

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]  strobe_i,
    output seqdet_pkg::strobe_cls_e cls_o,
    output logic [IDX_W-1:0]      idx_o
);
    import seqdet_pkg::*;

    localparam int CNT_W = $clog2(NUM_LINES + 1);

    logic [CNT_W-1:0] active_cnt;
    logic [IDX_W-1:0] low_idx;

    // Count active lines and pick the index of the active line.
    always_comb begin
        active_cnt = '0;
        low_idx    = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (strobe_i[k]) begin
                active_cnt = active_cnt + CNT_W'(1);
                low_idx    = IDX_W'(k);
            end
        end
    end

    always_comb begin
        if (active_cnt == '0) begin
            cls_o = CLS_NONE;
        end else if (active_cnt == CNT_W'(1)) begin
            cls_o = CLS_SINGLE;
        end else begin
            cls_o = CLS_MULTI;
        end
        idx_o = low_idx;
    end

endmodule

// File: rtl/repeat_tracker.sv
module repeat_tracker #(
    parameter int IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  seqdet_pkg::strobe_cls_e cls_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic                    repeat_o
);
    import seqdet_pkg::*;

    logic             have_last_q;
    logic [IDX_W-1:0] last_idx_q;

    // Remember the line of the last single strobe; a collision forgets it.
    always_ff @(posedge clk) begin
        if (rst) begin
            have_last_q <= 1'b0;
            last_idx_q  <= '0;
        end else begin
            unique case (cls_i)
                CLS_SINGLE: begin
                    have_last_q <= 1'b1;
                    last_idx_q  <= idx_i;
                end
                CLS_MULTI: begin
                    have_last_q <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        repeat_o = (cls_i == CLS_SINGLE) && have_last_q && (last_idx_q == idx_i);
    end

    // R8
    collision_forget_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_i == CLS_MULTI) |=> !repeat_o);

    // R4
    repeat_needs_single_chk: assert property (@(posedge clk) disable iff (rst)
        repeat_o |-> (cls_i == CLS_SINGLE) && have_last_q);

endmodule

// File: rtl/seq_step_logic.sv
module seq_step_logic #(
    parameter int IDX_W  = 2,
    parameter int STEP_A = 1,
    parameter int STEP_B = 3,
    parameter int STEP_C = 2,
    parameter int STEP_D = 0
) (
    input  seqdet_pkg::seq_state_e  state_i,
    input  seqdet_pkg::strobe_cls_e cls_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    repeat_i,
    output seqdet_pkg::seq_state_e  next_o
);
    import seqdet_pkg::*;

    logic             want_valid;
    logic [IDX_W-1:0] want_idx;
    seq_state_e       adv_state;

    // The line each state waits for, and where that line leads.
    always_comb begin
        want_valid = 1'b1;
        want_idx   = '0;
        adv_state  = ST_IDLE;
        unique case (state_i)
            ST_IDLE: begin
                want_idx  = IDX_W'(STEP_A);
                adv_state = ST_FIRST;
            end
            ST_FIRST: begin
                want_idx  = IDX_W'(STEP_B);
                adv_state = ST_SECOND;
            end
            ST_SECOND: begin
                want_idx  = IDX_W'(STEP_C);
                adv_state = ST_THIRD;
            end
            ST_THIRD: begin
                want_idx  = IDX_W'(STEP_D);
                adv_state = ST_MATCH;
            end
            default: begin
                want_valid = 1'b0;
            end
        endcase
    end

    // Priority: collision, repeat, advance, restart, mismatch.
    always_comb begin
        next_o = state_i;
        unique case (cls_i)
            CLS_NONE: begin
                next_o = state_i;
            end
            CLS_MULTI: begin
                next_o = ST_IDLE;
            end
            default: begin
                if (repeat_i) begin
                    next_o = ST_IDLE;
                end else if (want_valid && idx_i == want_idx) begin
                    next_o = adv_state;
                end else if (idx_i == IDX_W'(STEP_A)) begin
                    next_o = ST_FIRST;
                end else begin
                    next_o = ST_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/seq_pulse_detector.sv
module seq_pulse_detector #(
    parameter int NUM_LINES = 4,
    parameter int STEP_A    = 1,
    parameter int STEP_B    = 3,
    parameter int STEP_C    = 2,
    parameter int STEP_D    = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] strobe_i,
    output logic                 match_o,
    output logic [2:0]           state_o
);
    import seqdet_pkg::*;

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    strobe_cls_e      cls;
    logic [IDX_W-1:0] idx;
    logic             rep;
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic             match_q;

    strobe_decode #(.NUM_LINES(NUM_LINES)) u_decode (
        .strobe_i (strobe_i),
        .cls_o    (cls),
        .idx_o    (idx)
    );

    repeat_tracker #(.IDX_W(IDX_W)) u_repeat (
        .clk      (clk),
        .rst      (rst),
        .cls_i    (cls),
        .idx_i    (idx),
        .repeat_o (rep)
    );

    seq_step_logic #(
        .IDX_W  (IDX_W),
        .STEP_A (STEP_A),
        .STEP_B (STEP_B),
        .STEP_C (STEP_C),
        .STEP_D (STEP_D)
    ) u_step (
        .state_i  (state_q),
        .cls_i    (cls),
        .idx_i    (idx),
        .repeat_i (rep),
        .next_o   (state_d)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: Moore output, decoded from the next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_MATCH: match_q <= 1'b1;
                default:  match_q <= 1'b0;
            endcase
        end
    end

    assign match_o = match_q;
    assign state_o = state_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE) && !match_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i == '0) |=> $stable(state_q) && $stable(match_o));

    // R8
    collision_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(strobe_i) > 1) |=> (state_q == ST_IDLE) && !match_o);

    // R4
    repeat_drop_chk: assert property (@(posedge clk) disable iff (rst)
        rep |=> (state_q == ST_IDLE));

    // R2
    complete_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_THIRD) && $onehot(strobe_i) && strobe_i[STEP_D] && !rep
        |=> match_o);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && $onehot(strobe_i) && strobe_i[STEP_A] && !rep
        |=> (state_q == ST_FIRST));

    // R9
    match_level_chk: assert property (@(posedge clk) disable iff (rst)
        match_o == (state_q == ST_MATCH));

endmodule

// File: tb/test_seq_pulse_detector.sv
`timescale 1ns/1ps
module test_seq_pulse_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] strobe_i = 4'b0;
    logic       match_o;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;

    // Bench model: progress 0..4 and the previous strobe line.
    int prog = 0;
    bit last_v = 1'b0;
    int last_idx = 0;

    always #5 clk = ~clk;

    seq_pulse_detector i_seq_pulse_detector (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .match_o  (match_o),
        .state_o  (state_o)
    );

    function automatic int want_line(int p);
        case (p)
            0: return 1;
            1: return 3;
            2: return 2;
            3: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic compare(string tag);
        checks++;
        if (int'(state_o) != prog || match_o != (prog == 4)) begin
            errors++;
            $display("FAIL %s state=%0d exp=%0d match=%0b exp=%0b",
                     tag, state_o, prog, match_o, (prog == 4));
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        prog = 0;
        last_v = 1'b0;
        compare("R1");
    endtask

    // Apply one cycle of strobes, update the model, check the result.
    task automatic step(logic [3:0] v);
        string tag;
        int idx;
        @(negedge clk) strobe_i = v;
        @(negedge clk) strobe_i = 4'b0;
        idx = 0;
        for (int k = 3; k >= 0; k--) if (v[k]) idx = k;
        if (v == 4'b0) begin
            tag = (prog == 4) ? "R9" : "R7";
        end else if ($countones(v) > 1) begin
            tag = "R8"; prog = 0; last_v = 1'b0;
        end else begin
            if (last_v && idx == last_idx) begin
                tag = "R4"; prog = 0;
            end else if (idx == want_line(prog)) begin
                prog = prog + 1;
                tag = (prog == 4) ? "R2" : "R3";
            end else if (idx == 1) begin
                tag = "R6"; prog = 1;
            end else begin
                tag = "R5"; prog = 0;
            end
            last_v = 1'b1;
            last_idx = idx;
        end
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (2) @(negedge clk);
        // R10: reset code visible on the debug port
        do_reset();
        checks++;
        if (state_o != 3'd0) begin
            errors++;
            $display("FAIL R10 state=%0d exp=0", state_o);
        end

        // Directed: full order with gaps, then held through idle cycles.
        step(4'b0010); step(4'b0000); step(4'b1000); step(4'b0000);
        step(4'b0000); step(4'b0100); step(4'b0001);
        for (int g = 0; g < 4; g++) step(4'b0000);   // R9 hold
        step(4'b0010);                               // R6 restart from MATCH
        step(4'b0010);                               // R4 repeat of line 2
        step(4'b0010);                               // R4 again
        // R8: collision clears the repeat record
        do_reset();
        step(4'b0010); step(4'b0110); step(4'b0010); // second is not a repeat
        step(4'b1000); step(4'b0100); step(4'b0001);
        step(4'b0001);                               // R4 repeat after MATCH
        // Reset in the middle of a sequence
        do_reset();
        step(4'b0010); step(4'b1000); step(4'b0100);
        do_reset();
        step(4'b0001);                               // R5 no progress kept
        step(4'b1000);                               // R5

        // Sweep every four-strobe word with varying gaps.
        for (int s = 0; s < 256; s++) begin
            do_reset();
            for (int k = 0; k < 4; k++) begin
                step(4'b0001 << ((s >> (2 * k)) & 3));
                for (int g = 0; g < (s + k) % 3; g++) step(4'b0000);
            end
        end

        // Pseudo-random mixed run without reset.
        lfsr = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0:    step(lfsr[7:4] | 4'b0011);
                3'd1:    step(4'b0000);
                default: step(4'b0001 << lfsr[9:8]);
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule